// File: doc/BRIEF.md
# Real-time counter with alarm and periodic timer

This block keeps a free-running 40-bit real-time count that advances on a 32.768 kHz tick. At that rate one second is 2^15 ticks, so the seconds value is the count shifted right by 15. The count is read as a low word and a high byte at separate addresses. Software can stop each of the two parts on its own, or hold the whole count at zero with a clear bit. A 40-bit alarm value is compared against the count. A down-counter running on a separate timer clock enable fires once every reload+1 timer clocks. Software programs the reload as the timer clock divided by the wanted rate, minus one.

Three events set sticky status flags: counter rollover, alarm match and periodic tick. Software clears a flag by writing a 1 to it. Each flag has its own mask bit, and the flag drives its interrupt output only while that bit is set. Access goes through a plain single-cycle register bus. A write takes effect at the clock edge, and read data is combinational from the address.

Register map (word addresses, 32-bit data):
- 0 control: bit0 periodic enable, bit1 periodic freeze, bit2 freeze high byte, bit3 freeze low word, bit4 clear.
- 1 count low word (read only). 2 count high byte (read only).
- 3 alarm low word. 4 alarm high byte; only the low 8 bits are stored.
- 5 periodic reload. 6 status (write 1 to clear). 7 interrupt mask. 8 current periodic down-count (read only).
- Status and mask bits: bit31 rollover, bit30 alarm, bit29 periodic.

Top module: `rtc_alarm_timer`

## Requirements
- R1: After reset the count reads 0, the alarm reads all ones (low word 0xFFFFFFFF, high byte 0xFF), the reload, status and mask read 0, and all three interrupt outputs are low.
- R2: Each cycle with `rtc_tick` high increments the count low word by one, unless the low word is frozen or clear is set.
- R3: While control bit3 is set the low word ignores ticks, and while bit2 is set the high byte ignores ticks; a frozen part stays readable, and repeated reads return the same value.
- R4: When a tick moves the low word from all ones to zero, the high byte increments at the same clock edge unless the high byte is frozen, in which case that carry is lost.
- R5: While control bit4 (clear) is set the whole count is held at zero; after the bit is written back to 0, counting resumes from zero.
- R6: When the full 40-bit count wraps from all ones to zero, status bit31 is set.
- R7: Status bit30 is set on every clock edge at which the 40-bit count equals the alarm value {high byte, low word}; the alarm high register stores only 8 bits.
- R8: With control bit0 set and bit1 clear, the periodic counter starts at the reload value, decrements on each `tmr_tick` and, on the `tmr_tick` that finds it at zero, sets status bit29 and reloads; so it fires every reload+1 timer clocks. Bit1 stops it without losing its count.
- R9: Status bits are sticky. Writing 1 to a status bit clears it, writing 0 leaves it, and a new event in the same cycle wins over the clear. Each interrupt output is high exactly while its status bit and mask bit (same position in register 7) are both set.
- R10: Writing 0 to the control register stops the periodic timer and loads it with the reload value, so no periodic event occurs until it is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rtc_tick | input | 1 | One-cycle 32.768 kHz count enable |
| tmr_tick | input | 1 | One-cycle periodic timer clock enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_roll | output | 1 | Rollover interrupt |
| irq_alarm | output | 1 | Alarm interrupt |
| irq_per | output | 1 | Periodic interrupt |

## Verification
The hardest state to reach from the ports is a wrap of the full count, because the count has no load path and 2^40 ticks is out of reach. The bench therefore builds the block with a 12-bit count (8-bit low word, 4-bit high byte), so a wrap after clear takes 4096 ticks. The same width exposes the low-to-high carry with and without a frozen high byte. Random runs of ticks under random freeze settings are compared with a bench model of the split counter.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int unsigned DATA_W = 32;

   localparam int unsigned A_CTRL    = 0;
   localparam int unsigned A_CNT_LO  = 1;
   localparam int unsigned A_CNT_HI  = 2;
   localparam int unsigned A_ALM_LO  = 3;
   localparam int unsigned A_ALM_HI  = 4;
   localparam int unsigned A_RELOAD  = 5;
   localparam int unsigned A_STATUS  = 6;
   localparam int unsigned A_MASK    = 7;
   localparam int unsigned A_PER_NOW = 8;

   localparam int unsigned S_ROLL  = 31;
   localparam int unsigned S_ALARM = 30;
   localparam int unsigned S_PER   = 29;
   localparam int unsigned N_IRQ   = 3;

   // packed so that per_en lands on bit 0 and clear on bit 4
   typedef struct packed {
      logic clear;
      logic frz_lo;
      logic frz_hi;
      logic per_frz;
      logic per_en;
   } ctrl_t;
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
   parameter int unsigned LO_W = 32,
   parameter int unsigned HI_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            clear,
   input  logic            frz_lo,
   input  logic            frz_hi,
   output logic [LO_W-1:0] cnt_lo,
   output logic [HI_W-1:0] cnt_hi,
   output logic            wrap
);
   logic lo_step;
   logic carry;

   assign lo_step = tick && !frz_lo && !clear;
   assign carry   = lo_step && (&cnt_lo);
   assign wrap    = carry && !frz_hi && (&cnt_hi);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cnt_lo <= '0;
         cnt_hi <= '0;
      end else begin
         if (lo_step)
            cnt_lo <= cnt_lo + 1'b1;
         if (carry && !frz_hi)
            cnt_hi <= cnt_hi + 1'b1;
      end
   end
endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
   parameter int unsigned PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tmr_tick,
   input  logic             en,
   input  logic             frz,
   input  logic [PER_W-1:0] reload,
   output logic [PER_W-1:0] cnt,
   output logic             fire
);
   logic at_zero;
   logic step;

   assign at_zero = (cnt == '0);
   assign step    = en && !frz && tmr_tick;
   assign fire    = step && at_zero;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (!en)
         cnt <= reload;
      else if (step)
         cnt <= at_zero ? reload : cnt - 1'b1;
   end
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] w1c,
   input  logic [N-1:0] mask,
   output logic [N-1:0] status,
   output logic [N-1:0] irq
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)
            status[i] <= 1'b0;
         else
            status[i] <= set[i] | (status[i] & ~w1c[i]);
      end
      assign irq[i] = status[i] & mask[i];
   end
endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer
   import rtc_pkg::*;
#(
   parameter int unsigned LO_W   = 32,
   parameter int unsigned HI_W   = 8,
   parameter int unsigned PER_W  = 16,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rtc_tick,
   input  logic              tmr_tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_roll,
   output logic              irq_alarm,
   output logic              irq_per
);
   localparam int unsigned CNT_W = LO_W + HI_W;
   localparam int unsigned S_LOW = S_PER;

   if (LO_W < 1 || LO_W > DATA_W) begin : g_bad_lo
      $error("LO_W must be 1..32");
   end
   if (HI_W < 1 || HI_W > DATA_W) begin : g_bad_hi
      $error("HI_W must be 1..32");
   end
   if (PER_W < 1 || PER_W > DATA_W) begin : g_bad_per
      $error("PER_W must be 1..32");
   end
   if ((2 ** ADDR_W) <= A_PER_NOW) begin : g_bad_addr
      $error("ADDR_W too small for register map");
   end

   ctrl_t              ctrl_q;
   logic [LO_W-1:0]    alm_lo;
   logic [HI_W-1:0]    alm_hi;
   logic [PER_W-1:0]   reload_q;
   logic [N_IRQ-1:0]   mask_q;
   logic [LO_W-1:0]    cnt_lo;
   logic [HI_W-1:0]    cnt_hi;
   logic               wrap;
   logic [PER_W-1:0]   per_now;
   logic               per_fire;
   logic               alarm_hit;
   logic [N_IRQ-1:0]   ev_set;
   logic [N_IRQ-1:0]   ev_w1c;
   logic [N_IRQ-1:0]   status;
   logic [N_IRQ-1:0]   irq_vec;

   function automatic logic sel(input logic [ADDR_W-1:0] a, input int unsigned r);
      return a == ADDR_W'(r);
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         alm_lo   <= '1;
         alm_hi   <= '1;
         reload_q <= '0;
         mask_q   <= '0;
      end else if (bus_wr) begin
         if (sel(bus_addr, A_CTRL))   ctrl_q   <= ctrl_t'(bus_wdata[4:0]);
         if (sel(bus_addr, A_ALM_LO)) alm_lo   <= bus_wdata[LO_W-1:0];
         if (sel(bus_addr, A_ALM_HI)) alm_hi   <= bus_wdata[HI_W-1:0];
         if (sel(bus_addr, A_RELOAD)) reload_q <= bus_wdata[PER_W-1:0];
         if (sel(bus_addr, A_MASK))   mask_q   <= bus_wdata[S_ROLL:S_LOW];
      end
   end

   rtc_counter #(.LO_W(LO_W), .HI_W(HI_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (rtc_tick),
      .clear  (ctrl_q.clear),
      .frz_lo (ctrl_q.frz_lo),
      .frz_hi (ctrl_q.frz_hi),
      .cnt_lo (cnt_lo),
      .cnt_hi (cnt_hi),
      .wrap   (wrap)
   );

   rtc_periodic #(.PER_W(PER_W)) u_per (
      .clk      (clk),
      .rst_n    (rst_n),
      .tmr_tick (tmr_tick),
      .en       (ctrl_q.per_en),
      .frz      (ctrl_q.per_frz),
      .reload   (reload_q),
      .cnt      (per_now),
      .fire     (per_fire)
   );

   assign alarm_hit = ({cnt_hi, cnt_lo} == {alm_hi, alm_lo});
   assign ev_set    = {wrap, alarm_hit, per_fire};
   assign ev_w1c    = (bus_wr && sel(bus_addr, A_STATUS)) ? bus_wdata[S_ROLL:S_LOW] : '0;

   rtc_irq_flags #(.N(N_IRQ)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (ev_set),
      .w1c    (ev_w1c),
      .mask   (mask_q),
      .status (status),
      .irq    (irq_vec)
   );

   assign irq_roll  = irq_vec[2];
   assign irq_alarm = irq_vec[1];
   assign irq_per   = irq_vec[0];

   always_comb begin
      bus_rdata = '0;
      if (sel(bus_addr, A_CTRL))    bus_rdata[4:0] = ctrl_q;
      if (sel(bus_addr, A_CNT_LO))  bus_rdata = DATA_W'(cnt_lo);
      if (sel(bus_addr, A_CNT_HI))  bus_rdata = DATA_W'(cnt_hi);
      if (sel(bus_addr, A_ALM_LO))  bus_rdata = DATA_W'(alm_lo);
      if (sel(bus_addr, A_ALM_HI))  bus_rdata = DATA_W'(alm_hi);
      if (sel(bus_addr, A_RELOAD))  bus_rdata = DATA_W'(reload_q);
      if (sel(bus_addr, A_STATUS))  bus_rdata[S_ROLL:S_LOW] = status;
      if (sel(bus_addr, A_MASK))    bus_rdata[S_ROLL:S_LOW] = mask_q;
      if (sel(bus_addr, A_PER_NOW)) bus_rdata = DATA_W'(per_now);
   end
endmodule

// File: rtl/rtc_alarm_timer_chk.sv
module rtc_alarm_timer_chk #(
   parameter int unsigned LO_W   = 32,
   parameter int unsigned HI_W   = 8,
   parameter int unsigned PER_W  = 16,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [LO_W-1:0]   cnt_lo,
   input logic [HI_W-1:0]   cnt_hi,
   input logic [LO_W-1:0]   alm_lo,
   input logic [HI_W-1:0]   alm_hi,
   input logic              clear_q,
   input logic              frz_lo_q,
   input logic              frz_hi_q,
   input logic              per_en_q,
   input logic              per_frz_q,
   input logic [PER_W-1:0]  per_now,
   input logic [2:0]        status,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata
);
   localparam int unsigned CNT_W = LO_W + HI_W;

   logic [CNT_W-1:0] full;
   logic [2:0]       w1c;
   assign full = {cnt_hi, cnt_lo};
   assign w1c  = (bus_wr && bus_addr == ADDR_W'(6)) ? bus_wdata[31:29] : 3'b000;

   AST_FROZEN_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_lo_q && !clear_q) |=> $stable(cnt_lo));                       // R3

   AST_FROZEN_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_hi_q && !clear_q) |=> $stable(cnt_hi));                       // R3

   AST_CLEAR_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clear_q |=> (full == '0));                                         // R5

   AST_WRAP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (full == '0 && $past(full) == {CNT_W{1'b1}} && !$past(clear_q))
      |-> status[2]);                                                    // R6

   AST_ALARM_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (full == {alm_hi, alm_lo}) |=> status[1]);                         // R7

   AST_PER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (per_en_q && per_frz_q) |=> $stable(per_now));                     // R8

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (status & ~w1c) != 3'b000 |=> ((status & $past(status & ~w1c)) == $past(status & ~w1c))); // R9
endmodule

bind rtc_alarm_timer rtc_alarm_timer_chk #(
   .LO_W(LO_W), .HI_W(HI_W), .PER_W(PER_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cnt_lo    (cnt_lo),
   .cnt_hi    (cnt_hi),
   .alm_lo    (alm_lo),
   .alm_hi    (alm_hi),
   .clear_q   (ctrl_q.clear),
   .frz_lo_q  (ctrl_q.frz_lo),
   .frz_hi_q  (ctrl_q.frz_hi),
   .per_en_q  (ctrl_q.per_en),
   .per_frz_q (ctrl_q.per_frz),
   .per_now   (per_now),
   .status    (status),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata)
);

// File: tb/test_rtc_alarm_timer.sv
module test_rtc_alarm_timer;
   localparam int LO_W = 8;
   localparam int HI_W = 4;
   localparam int PER_W = 8;
   localparam int ADDR_W = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rtc_tick = 1'b0;
   logic              tmr_tick = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              irq_roll, irq_alarm, irq_per;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int m_lo, m_hi;

   always #4 clk = ~clk;

   rtc_alarm_timer #(.LO_W(LO_W), .HI_W(HI_W), .PER_W(PER_W), .ADDR_W(ADDR_W)) i_rtc_alarm_timer (
      .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .tmr_tick(tmr_tick),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_roll(irq_roll), .irq_alarm(irq_alarm), .irq_per(irq_per)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      bus_addr = ADDR_W'(a); bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      bus_addr = ADDR_W'(a); #1; d = bus_rdata;
   endtask

   task automatic ticks(input int n);
      repeat (n) begin
         rtc_tick = 1'b1; @(posedge clk); @(negedge clk); rtc_tick = 1'b0;
      end
   endtask

   task automatic tticks(input int n);
      repeat (n) begin
         tmr_tick = 1'b1; @(posedge clk); @(negedge clk); tmr_tick = 1'b0;
      end
   endtask

   // reference model of one tick of the split counter
   function automatic void model_tick(input bit flo, input bit fhi);
      if (!flo) begin
         if (m_lo == (1 << LO_W) - 1) begin
            m_lo = 0;
            if (!fhi) m_hi = (m_hi + 1) % (1 << HI_W);
         end else m_lo = m_lo + 1;
      end
   endfunction

   function automatic logic [31:0] ctrl_word(input bit clr, input bit flo, input bit fhi,
                                             input bit pfrz, input bit pen);
      return {27'd0, clr, flo, fhi, pfrz, pen};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, v2;
      void'($urandom(32'd20240611));
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(1, v); chk("R1 cnt lo", v, 0);
      rd(2, v); chk("R1 cnt hi", v, 0);
      rd(3, v); chk("R1 alarm lo", v, 32'hFF);
      rd(4, v); chk("R1 alarm hi", v, 32'hF);
      rd(5, v); chk("R1 reload", v, 0);
      rd(6, v); chk("R1 status", v, 0);
      rd(7, v); chk("R1 mask", v, 0);
      chk("R1 irqs", {29'd0, irq_roll, irq_alarm, irq_per}, 0);

      // R2 plain counting
      ticks(10);
      rd(1, v); chk("R2 count 10", v, 10);
      idle(5);
      rd(1, v); chk("R2 no tick no change", v, 10);

      // R3 low word freeze
      wr(0, ctrl_word(0, 1, 0, 0, 0));
      ticks(5);
      rd(1, v); rd(1, v2);
      chk("R3 frozen lo", v, 10);
      chk("R3 repeated read", v2, v);
      wr(0, 0);

      // R4 carry into high byte
      wr(0, ctrl_word(1, 0, 0, 0, 0)); wr(0, 0);
      ticks(255);
      rd(1, v); chk("R4 lo at max", v, 255);
      rd(2, v); chk("R4 hi before carry", v, 0);
      ticks(1);
      rd(1, v); chk("R4 lo wrapped", v, 0);
      rd(2, v); chk("R4 hi carried", v, 1);

      // R4/R3 carry lost with high byte frozen
      wr(0, ctrl_word(0, 0, 1, 0, 0));
      ticks(256);
      rd(1, v); chk("R3 lo counts while hi frozen", v, 0);
      rd(2, v); chk("R4 carry lost while hi frozen", v, 1);
      wr(0, 0);

      // R5 clear holds zero
      wr(0, ctrl_word(1, 0, 0, 0, 0));
      ticks(7);
      rd(1, v); chk("R5 held lo", v, 0);
      rd(2, v); chk("R5 held hi", v, 0);
      wr(0, 0);
      ticks(3);
      rd(1, v); chk("R5 resumes from zero", v, 3);

      // R6 full wrap, R9 mask and w1c
      wr(0, ctrl_word(1, 0, 0, 0, 0)); wr(0, 0);
      wr(6, 32'hE000_0000);
      ticks(4095);
      rd(6, v); chk("R6 no flag before wrap", v & 32'h8000_0000, 0);
      ticks(1);
      rd(1, v); chk("R6 lo after wrap", v, 0);
      rd(2, v); chk("R6 hi after wrap", v, 0);
      rd(6, v); chk("R6 roll flag", v & 32'h8000_0000, 32'h8000_0000);
      chk("R9 masked irq low", {31'd0, irq_roll}, 0);
      wr(7, 32'h8000_0000);
      chk("R9 unmasked irq high", {31'd0, irq_roll}, 1);
      wr(6, 32'h4000_0000);
      rd(6, v); chk("R9 write of other bit keeps roll", v & 32'h8000_0000, 32'h8000_0000);
      wr(6, 32'h8000_0000);
      rd(6, v); chk("R9 roll cleared", v & 32'h8000_0000, 0);
      chk("R9 irq drops", {31'd0, irq_roll}, 0);

      // R7 alarm match
      wr(4, 32'hFFFF_FF00);
      rd(4, v); chk("R7 alarm hi masked", v, 0);
      wr(3, 20);
      wr(0, ctrl_word(1, 0, 0, 0, 0)); wr(0, 0);
      wr(6, 32'hE000_0000);
      ticks(19); idle(1);
      rd(6, v); chk("R7 no alarm at 19", v & 32'h4000_0000, 0);
      ticks(1); idle(1);
      rd(6, v); chk("R7 alarm at 20", v & 32'h4000_0000, 32'h4000_0000);
      wr(7, 32'h4000_0000);
      chk("R9 alarm irq", {31'd0, irq_alarm}, 1);
      wr(4, 32'hF); wr(3, 32'hFF);
      wr(6, 32'hE000_0000);
      idle(1);
      rd(6, v); chk("R9 alarm cleared", v & 32'h4000_0000, 0);

      // R8 periodic every reload+1
      wr(5, 3);
      wr(0, ctrl_word(0, 0, 0, 0, 1));
      tticks(3);
      rd(6, v); chk("R8 no fire after 3", v & 32'h2000_0000, 0);
      tticks(1);
      rd(6, v); chk("R8 fire on 4th", v & 32'h2000_0000, 32'h2000_0000);
      rd(8, v); chk("R8 reloaded", v, 3);
      wr(6, 32'h2000_0000);
      tticks(3);
      rd(6, v); chk("R8 second period not yet", v & 32'h2000_0000, 0);
      wr(0, ctrl_word(0, 0, 0, 1, 1));
      tticks(5);
      rd(6, v); chk("R8 frozen no fire", v & 32'h2000_0000, 0);
      rd(8, v); chk("R8 frozen count kept", v, 0);
      wr(0, ctrl_word(0, 0, 0, 0, 1));
      tticks(1);
      rd(6, v); chk("R8 fires after unfreeze", v & 32'h2000_0000, 32'h2000_0000);
      wr(7, 32'h2000_0000);
      chk("R9 periodic irq", {31'd0, irq_per}, 1);
      wr(6, 32'h2000_0000);

      // R10 control cleared stops periodic
      wr(0, 0);
      rd(8, v); chk("R10 reload loaded", v, 3);
      tticks(12);
      rd(6, v); chk("R10 no periodic event", v & 32'h2000_0000, 0);

      // R2/R3/R4 random runs against model
      wr(0, ctrl_word(1, 0, 0, 0, 0)); wr(0, 0);
      m_lo = 0; m_hi = 0;
      for (int it = 0; it < 24; it++) begin
         bit flo, fhi;
         int n;
         flo = 1'($urandom_range(0, 3) == 0);
         fhi = 1'($urandom_range(0, 2) == 0);
         n = $urandom_range(1, 600);
         wr(0, ctrl_word(0, flo, fhi, 0, 0));
         for (int k = 0; k < n; k++) model_tick(flo, fhi);
         ticks(n);
         rd(1, v); chk("R2 random lo", v, 32'(m_lo));
         rd(2, v); chk("R4 random hi", v, 32'(m_hi));
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule